// File: doc/BRIEF.md
# Return-Address Hash Digest Unit

This block computes a 64-bit keyed digest from a return address and a stack pointer. The digest helps to detect tampering with return addresses. Software or a pipeline stage writes the digest to the stack when a function is entered. Before the return, it presents the stored value again and asks the unit to compare it.

A new job starts with a one-cycle `start` pulse while the unit is idle. The two operands are first shuffled byte by byte into two 64-bit words. These words are then split into four 32-bit lanes. Each lane runs through a 32-round Feistel network with 16-bit halves. All four lanes share one 64-bit key, but each lane reads the expanded key schedule in its own rotated order. The unit computes one round per cycle, in all four lanes at once. The key schedule is expanded on the fly, four words at a time.

When the rounds finish, `done` pulses and the digest appears. In check mode the unit also raises `trap` if the supplied value differs from the digest.

Top module: `rop_hash_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy`, `done` and `trap` are 0 and `digest` is all zeros until the first job completes.
- R2: The key is split into words k0=key[63:48], k1=key[47:32], k2=key[31:16] and k3=key[15:0]. Each further word k[i+4], for i=0..27, is computed as follows:
  - t = ror16(k[i+3],3) ^ k[i+1].
  - k[i+4] = 0xFFFC ^ z ^ k[i] ^ t ^ ror16(t,1).
  - z is bit (63-i) of 0xFA2561CDF44AC398.
- R3: Round r=4g+j of lane n uses the round key k[4g + ((j+n) mod 4)].
- R4: A lane input x starts with left half x[15:0] and right half x[31:16]. Each round computes f = (rol16(L,1) & rol16(L,8)) ^ rol16(L,2). The new left half is R ^ f ^ roundkey and the new right half is the old left half. The lane result is {right, left} after 32 rounds.
- R5: The operands are interleaved into two words, H and W, for byte index i = 0..3:
  - H: byte i of stack_ptr[63:32] goes to byte 2i, and byte i of ret_addr[31:0] goes to byte 7-2i.
  - W: byte i of stack_ptr[31:0] goes to byte 2i, and byte i of ret_addr[63:32] goes to byte 7-2i.
- R6: The lane inputs are assigned as follows: lane 0 takes H[63:32], lane 1 takes H[31:0], lane 2 takes W[63:32] and lane 3 takes W[31:0]. The digest is {lane0,lane1} ^ {lane2,lane3}.
- R7: Timing of a job:
  - A `start` seen while idle makes `busy` 1 for exactly 32 cycles.
  - `done` is then 1 for one cycle with `busy` low.
  - `digest` and `trap` change only in that cycle and hold until the next completion.
- R8: A `start` while `busy` is 1 is ignored. The operands, key, mode and compare value are sampled only in the cycle a job is accepted.
- R9: `check_mode`=1 selects check mode, and 0 selects store mode. In check mode `trap` is 1 exactly when `ref_hash` differs from the digest. In store mode `trap` is 0.
- R10: A `start` in the cycle where `done` is 1 is accepted, so jobs can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job when idle |
| check_mode | input | 1 | 1 = compare against `ref_hash`, 0 = produce digest only |
| ret_addr | input | 64 | Return address operand |
| stack_ptr | input | 64 | Stack pointer operand |
| key | input | 64 | Hash key |
| ref_hash | input | 64 | Previously stored digest for check mode |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | Check-mode mismatch, held until the next completion |
| digest | output | 64 | Computed digest, held until the next completion |

## Verification
The completion of one job and the acceptance of the next can fall in the same cycle: `done` pulses and `busy` is already low, so a waiting `start` is taken. The bench provokes this by holding `start` high across many consecutive jobs while it changes the operands every cycle. A behavioural reference model then predicts, cycle by cycle, which input set each job captured. The bench also pulses `start` in the middle of a run with different data. It judges the run by whether `busy`, `done`, `digest` and `trap` match the model on every clock.

// File: rtl/rop_hash_unit.sv
module rop_hash_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        check_mode,
  input  logic [63:0] ret_addr,
  input  logic [63:0] stack_ptr,
  input  logic [63:0] key,
  input  logic [63:0] ref_hash,
  output logic        busy,
  output logic        done,
  output logic        trap,
  output logic [63:0] digest
);

  localparam int          LANES  = 4;
  localparam int          ROUNDS = 32;
  localparam int          RW     = $clog2(ROUNDS);
  localparam logic [15:0] KCONST = 16'hFFFC;
  localparam logic [63:0] ZSEQ   = 64'hFA2561CDF44AC398;

  function automatic logic [15:0] rol16(input logic [15:0] v, input int n);
    return (v << n) | (v >> (16 - n));
  endfunction

  function automatic logic [15:0] ror16(input logic [15:0] v, input int n);
    return (v >> n) | (v << (16 - n));
  endfunction

  function automatic logic [15:0] kstep(input logic [15:0] a, input logic [15:0] b,
                                        input logic [15:0] d, input logic zb);
    logic [15:0] t;
    t = ror16(d, 3) ^ b;
    return KCONST ^ {15'd0, zb} ^ a ^ t ^ ror16(t, 1);
  endfunction

  logic [RW-1:0]          rnd;
  logic                   chk_q;
  logic [63:0]            ref_q;
  logic [3:0][15:0]       kw, kn;
  logic [LANES-1:0][15:0] lft, rgt, nl;
  logic [LANES-1:0][31:0] lane_in;
  logic [63:0]            hw, ww, dig_next;
  logic [5:0]             zbase;
  logic                   accept, last;

  assign accept = start && !busy;
  assign last   = busy && (rnd == RW'(ROUNDS - 1));

  always_comb begin
    hw = '0;
    ww = '0;
    for (int i = 0; i < 4; i++) begin
      hw[16*i +: 8]      = stack_ptr[32 + 8*i +: 8];
      hw[8*(7-2*i) +: 8] = ret_addr[8*i +: 8];
      ww[16*i +: 8]      = stack_ptr[8*i +: 8];
      ww[8*(7-2*i) +: 8] = ret_addr[32 + 8*i +: 8];
    end
  end

  assign lane_in[0] = hw[63:32];
  assign lane_in[1] = hw[31:0];
  assign lane_in[2] = ww[63:32];
  assign lane_in[3] = ww[31:0];

  assign zbase = {1'b0, rnd[RW-1:2], 2'b00};
  assign kn[0] = kstep(kw[0], kw[1], kw[3], ZSEQ[6'd63 - zbase]);
  assign kn[1] = kstep(kw[1], kw[2], kn[0], ZSEQ[6'd62 - zbase]);
  assign kn[2] = kstep(kw[2], kw[3], kn[1], ZSEQ[6'd61 - zbase]);
  assign kn[3] = kstep(kw[3], kn[0], kn[2], ZSEQ[6'd60 - zbase]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      rnd   <= '0;
      chk_q <= 1'b0;
      ref_q <= '0;
      kw    <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        rnd <= rnd + RW'(1);
        if (rnd[1:0] == 2'd3) kw <= kn;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        busy  <= 1'b1;
        rnd   <= '0;
        chk_q <= check_mode;
        ref_q <= ref_hash;
        kw    <= {key[15:0], key[31:16], key[47:32], key[63:48]};
      end
    end
  end

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic [1:0]  sel;
    logic [15:0] fx;
    assign sel   = rnd[1:0] + 2'(n);
    assign fx    = (rol16(lft[n], 1) & rol16(lft[n], 8)) ^ rol16(lft[n], 2);
    assign nl[n] = rgt[n] ^ fx ^ kw[sel];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lft[n] <= '0;
        rgt[n] <= '0;
      end else if (accept) begin
        lft[n] <= lane_in[n][15:0];
        rgt[n] <= lane_in[n][31:16];
      end else if (busy) begin
        lft[n] <= nl[n];
        rgt[n] <= lft[n];
      end
    end
  end

  assign dig_next = {lft[0], nl[0], lft[1], nl[1]} ^ {lft[2], nl[2], lft[3], nl[3]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      digest <= '0;
      trap   <= 1'b0;
    end else if (last) begin
      digest <= dig_next;
      trap   <= chk_q && (ref_q != dig_next);
    end
  end

endmodule

// File: rtl/rop_hash_unit_checker.sv
module rop_hash_unit_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        trap,
  input logic [63:0] digest,
  input logic        chk_q,
  input logic [4:0]  rnd
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R7
  AST_DIGEST_HELD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(digest)); // R7
  AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (busy && rnd != 5'd31) |=> busy); // R7
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start && rnd != 5'd31) |=> $stable(chk_q)); // R8
  AST_TRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(trap)); // R9
  AST_STORE_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n) (done && !$past(chk_q)) |-> !trap); // R9

endmodule

bind rop_hash_unit rop_hash_unit_checker u_rop_hash_unit_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .trap(trap), .digest(digest), .chk_q(chk_q), .rnd(rnd)
);

// File: tb/rop_hash_unit_bench.sv
module rop_hash_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        check_mode = 1'b0;
  logic [63:0] ret_addr = '0, stack_ptr = '0, key = '0, ref_hash = '0;
  logic        busy, done, trap;
  logic [63:0] digest;

  int compared = 0;
  int mismatched = 0;
  string phase = "R7";
  bit finished = 0;

  always #5 clk = ~clk;

  rop_hash_unit u_rop_hash_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .check_mode(check_mode),
    .ret_addr(ret_addr), .stack_ptr(stack_ptr), .key(key), .ref_hash(ref_hash),
    .busy(busy), .done(done), .trap(trap), .digest(digest)
  );

  function automatic logic [15:0] r16(input logic [15:0] v, input int n);
    int m;
    m = ((n % 16) + 16) % 16;
    return (v << m) | (v >> (16 - m));
  endfunction

  function automatic logic [31:0] lane_ref(input logic [31:0] x, input logic [63:0] k64, input int ln);
    logic [15:0] ks [32];
    logic [15:0] t, l, r, f, nx;
    logic [63:0] z0;
    z0 = 64'hFA2561CDF44AC398;
    for (int i = 0; i < 4; i++) ks[i] = k64[63 - 16*i -: 16];
    for (int i = 0; i < 28; i++) begin
      t = r16(ks[i+3], -3) ^ ks[i+1];
      ks[i+4] = 16'hFFFC ^ {15'd0, z0[63-i]} ^ ks[i] ^ t ^ r16(t, -1);
    end
    l = x[15:0];
    r = x[31:16];
    for (int rr = 0; rr < 32; rr++) begin
      f  = (r16(l, 1) & r16(l, 8)) ^ r16(l, 2);
      nx = r ^ f ^ ks[(rr / 4) * 4 + ((rr % 4 + ln) % 4)];
      r  = l;
      l  = nx;
    end
    return {r, l};
  endfunction

  function automatic logic [63:0] digest_ref(input logic [63:0] ra, input logic [63:0] sp, input logic [63:0] k64);
    logic [63:0] h, w;
    h = '0;
    w = '0;
    for (int i = 0; i < 4; i++) begin
      h[16*i +: 8]      = sp[32 + 8*i +: 8];
      h[56 - 16*i +: 8] = ra[8*i +: 8];
      w[16*i +: 8]      = sp[8*i +: 8];
      w[56 - 16*i +: 8] = ra[32 + 8*i +: 8];
    end
    return {lane_ref(h[63:32], k64, 0), lane_ref(h[31:0], k64, 1)} ^
           {lane_ref(w[63:32], k64, 2), lane_ref(w[31:0], k64, 3)};
  endfunction

  // Behavioural reference model, advanced on each rising edge
  bit          m_busy = 0, m_done = 0, m_trap = 0, s_chk = 0;
  int          m_cnt = 0;
  logic [63:0] m_dig = '0, s_ra, s_sp, s_key, s_ref;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_trap = 0; m_dig = '0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 32) begin
          m_busy = 0;
          m_done = 1;
          m_dig  = digest_ref(s_ra, s_sp, s_key);
          m_trap = s_chk && (s_ref != m_dig);
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0;
        s_chk = check_mode; s_ra = ret_addr; s_sp = stack_ptr; s_key = key; s_ref = ref_hash;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(busy == m_busy, "R7", "busy", 64'(busy), 64'(m_busy));
      check(done == m_done, phase, "done", 64'(done), 64'(m_done));
      check(digest == m_dig, phase, "digest (R2/R3/R4/R5/R6)", digest, m_dig);
      check(trap == m_trap, "R9", "trap", 64'(trap), 64'(m_trap));
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic run_job(input bit chk, input logic [63:0] ra, input logic [63:0] sp,
                         input logic [63:0] k64, input logic [63:0] rh);
    @(negedge clk);
    check_mode = chk; ret_addr = ra; stack_ptr = sp; key = k64; ref_hash = rh; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (34) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0 && done == 1'b0 && trap == 1'b0, "R1", "status in reset", {61'd0, busy, done, trap}, 64'd0);
    check(digest == 64'd0, "R1", "digest in reset", digest, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && digest == 64'd0, "R1", "state after reset", digest, 64'd0);

    // R2, R3, R4, R5, R6: store mode under distinct patterns
    phase = "R6";
    run_job(1'b0, 64'd0, 64'd0, 64'd0, 64'd0);
    run_job(1'b0, '1, '1, '1, 64'd0);
    run_job(1'b0, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h0F1E2D3C4B5A6978, 64'd0);
    run_job(1'b0, 64'h0000000000001000, 64'h00007FFFFFFFF000, 64'h8000000000000001, 64'd0);
    run_job(1'b0, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h0F1E2D3C4B5A6979, 64'd0);

    // R9: check mode, matching then mismatching value
    phase = "R9";
    run_job(1'b1, 64'hDEADBEEF00400000, 64'h00007FFC0000A0B0, 64'h1122334455667788,
            digest_ref(64'hDEADBEEF00400000, 64'h00007FFC0000A0B0, 64'h1122334455667788));
    check(trap == 1'b0, "R9", "trap on matching value", 64'(trap), 64'd0);
    run_job(1'b1, 64'hDEADBEEF00400000, 64'h00007FFC0000A0B0, 64'h1122334455667788,
            digest_ref(64'hDEADBEEF00400000, 64'h00007FFC0000A0B0, 64'h1122334455667788) ^ 64'd1);
    check(trap == 1'b1, "R9", "trap on mismatching value", 64'(trap), 64'd1);
    run_job(1'b0, 64'hDEADBEEF00400000, 64'h00007FFC0000A0B0, 64'h1122334455667788, 64'd5);
    check(trap == 1'b0, "R9", "trap in store mode", 64'(trap), 64'd0);

    // R8: start and data changes while busy are ignored
    phase = "R8";
    @(negedge clk);
    check_mode = 1'b0; ret_addr = 64'hA5A5A5A5A5A5A5A5; stack_ptr = 64'h3C3C3C3C3C3C3C3C;
    key = 64'h0102030405060708; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ret_addr = 64'h1; stack_ptr = 64'h2; key = 64'h3; check_mode = 1'b1; ref_hash = 64'h7;
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    check(digest == digest_ref(64'hA5A5A5A5A5A5A5A5, 64'h3C3C3C3C3C3C3C3C, 64'h0102030405060708),
          "R8", "digest of first accepted job", digest,
          digest_ref(64'hA5A5A5A5A5A5A5A5, 64'h3C3C3C3C3C3C3C3C, 64'h0102030405060708));

    // R10: start held high, completion and acceptance in one cycle
    phase = "R10";
    @(negedge clk);
    start = 1'b1;
    for (int c = 0; c < 140; c++) begin
      ret_addr  = {ret_addr[62:0], ret_addr[63] ^ ret_addr[60]} + 64'(c);
      stack_ptr = stack_ptr ^ {32'(c), 32'(c * 7)};
      key       = key + 64'h9E3779B97F4A7C15;
      check_mode = c[0];
      ref_hash  = (c % 3 == 0) ? 64'd0 : '1;
      @(negedge clk);
    end
    start = 1'b0;
    repeat (40) @(negedge clk);
    check(busy == 1'b0, "R10", "idle after back-to-back run", 64'(busy), 64'd0);

    finish_run();
  end

endmodule